// File: doc/BRIEF.md
# Word Load/Store Alignment Unit

This block sits between a 32-bit processor core and an external memory bus. It carries whole-word transfers whose byte address may not fall on a word boundary. It handles three operations: a word load, a word store, and an atomic swap. Each transfer is a single access on the bus, and no transfer raises a fault.

For a load, the block puts the core's byte address on the bus exactly as given. The word that comes back is rotated right by eight bits for each unit of the two-bit byte offset. For a store, the low two address bits are cleared, and the register value goes onto the bus with every bit in its original position.

A swap combines these two rules. It is a load followed by a store to the same word, and a lock output stays high across both phases so that no other bus master can get in between them. The core side and the memory side each use a request/ready handshake. Only one operation is in flight at a time.

Top module: `wa_align_unit`

## Requirements
- R1: After a synchronous reset the block is idle: `core_ready` is 1, while `core_done`, `mem_req` and `mem_lock` are 0.
- R2: Operation codes are `00` for load, `01` for store, `10` for swap and `11` for load. A load issues a read (`mem_we`=0) with the core byte address unchanged, including bits [1:0].
- R3: The value a load returns is the read word rotated right by 8 x addr[1:0] bits, so offset 0 leaves it unchanged and offsets 1, 2 and 3 rotate it by 8, 16 and 24 bits.
- R4: A load or a store makes exactly one bus access, whatever the offset.
- R5: Every write on the bus (`mem_we`=1) carries an address whose bits [1:0] are 00. Bits [31:2] are those of the core address.
- R6: The data of a store is the core value unshifted: core bit n drives bus bit n for every offset.
- R7: A swap makes exactly two bus accesses in this order. First comes a read at the full byte address, then a write at the same address with bits [1:0] cleared.
- R8: A swap returns the rotated read data to the core, per R3. It writes the unmodified source value to memory.
- R9: `mem_lock` is high in every cycle of a swap's read and write phases, and low at all other times, including throughout loads and stores.
- R10: `core_ready` is high only when the block is idle. A request held while the block is busy is ignored and causes no bus access.
- R11: While `mem_req` is high and `mem_ready` is low, the next cycle keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged.
- R12: `core_done` is a one-cycle pulse in the cycle after the final bus handshake, with the load or swap result on `core_rdata`. The block is ready again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core requests an operation |
| core_op | input | 2 | Operation code (see R2) |
| core_addr | input | 32 | Byte address |
| core_wdata | input | 32 | Source register value for store or swap |
| core_ready | output | 1 | Block is idle and accepts a request |
| core_done | output | 1 | Operation finished, result valid |
| core_rdata | output | 32 | Rotated load or swap result |
| mem_req | output | 1 | Bus access requested |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Memory completes the current access this cycle |
| mem_lock | output | 1 | Bus held locked across a swap |

## Verification
The assertions assume that memory raises `mem_ready` only while `mem_req` is high, and that each handshake completes exactly one access. The bench's memory model keeps to this: it answers only a pending request, after a programmable wait, and drops ready in the cycle after every handshake. The stimulus varies the wait between zero and three cycles. On some operations it keeps `core_req` asserted with a different operation code throughout the busy period, to show that such requests are ignored.

// File: rtl/wa_pkg.sv
package wa_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_SWAP  = 2'b10,
        OP_LOAD2 = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10,
        ST_RESP  = 2'b11
    } state_e;

    typedef struct packed {
        op_e         op;
        logic [31:0] addr;
        logic [31:0] wdata;
    } xfer_t;

    function automatic logic op_is_store(op_e op);
        return op == OP_STORE;
    endfunction

    function automatic logic op_is_swap(op_e op);
        return op == OP_SWAP;
    endfunction

endpackage

// File: rtl/wa_rotator.sv
module wa_rotator #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] word_out
);
    // Output lane i takes input lane (i + offset) mod LANES: rotate right by bytes.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFF_W-1:0] src;
        assign src = OFF_W'(i) + offset;
        assign word_out[8*i +: 8] = word_in[8*src +: 8];
    end
endmodule

// File: rtl/wa_addr_shaper.sv
module wa_addr_shaper #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 2
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              align,
    output logic [ADDR_W-1:0] addr_out
);
    always_comb begin
        addr_out = addr_in;
        if (align) begin
            addr_out[OFF_W-1:0] = '0;
        end
    end
endmodule

// File: rtl/wa_seq.sv
module wa_seq
    import wa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  op_e    start_op,
    input  op_e    cur_op,
    input  logic   mem_ready,
    output state_e state,
    output logic   lock
);
    state_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = op_is_store(start_op) ? ST_WRITE : ST_READ;
            ST_READ:  if (mem_ready) state_n = op_is_swap(cur_op) ? ST_WRITE : ST_RESP;
            ST_WRITE: if (mem_ready) state_n = ST_RESP;
            ST_RESP:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    assign lock = op_is_swap(cur_op) && (state == ST_READ || state == ST_WRITE);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && state == ST_READ && mem_ready) |=> (lock && state == ST_WRITE));

    // R9
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && state == ST_WRITE && mem_ready) |=> !lock);

    // R7
    swap_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && op_is_swap(start_op)) |=> (state == ST_READ));
endmodule

// File: rtl/wa_align_unit.sv
module wa_align_unit
    import wa_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned OFF_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req,
    input  logic [1:0]        core_op,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic              core_done,
    output logic [DATA_W-1:0] core_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              mem_lock
);
    state_e            state;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rot_word;
    logic              accept;

    assign core_ready = (state == ST_IDLE);
    assign accept     = core_req && core_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                op_q    <= op_e'(core_op);
                addr_q  <= core_addr;
                wdata_q <= core_wdata;
            end
            if (state == ST_READ && mem_ready) begin
                rdata_q <= rot_word;
            end
        end
    end

    wa_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .start_op  (op_e'(core_op)),
        .cur_op    (op_q),
        .mem_ready (mem_ready),
        .state     (state),
        .lock      (mem_lock)
    );

    wa_rotator #(.DATA_W(DATA_W)) i_rot (
        .word_in  (mem_rdata),
        .offset   (addr_q[OFF_W-1:0]),
        .word_out (rot_word)
    );

    wa_addr_shaper #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_addr (
        .addr_in  (addr_q),
        .align    (state == ST_WRITE),
        .addr_out (mem_addr)
    );

    assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we     = (state == ST_WRITE);
    assign mem_wdata  = wdata_q;
    assign core_done  = (state == ST_RESP);
    assign core_rdata = rdata_q;

    // R5
    store_align_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr[OFF_W-1:0] == '0));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !core_ready);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        core_done |=> (!core_done && core_ready));

    // R9
    lock_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_lock |-> mem_req);
endmodule

// File: tb/test_wa_align_unit.sv
module test_wa_align_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_req = 1'b0;
    logic [1:0]  core_op = 2'b00;
    logic [31:0] core_addr = '0;
    logic [31:0] core_wdata = '0;
    logic        core_ready, core_done;
    logic [31:0] core_rdata;
    logic        mem_req, mem_we, mem_lock;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wcnt = 0;
    int cycles = 0;

    logic [31:0] mem [16];
    logic        q_we   [$];
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];

    always #10 clk = ~clk;

    wa_align_unit i_wa_align_unit (
        .clk(clk), .rst(rst), .core_req(core_req), .core_op(core_op),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
        .core_done(core_done), .core_rdata(core_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_lock(mem_lock)
    );

    function automatic logic [31:0] ref_rot(logic [31:0] w, logic [1:0] off);
        int s;
        s = 8 * int'(off);
        if (s == 0) return w;
        return (w >> s) | (w << (32 - s));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: answers a pending request after lat wait cycles
    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                q_we.push_back(mem_we);
                q_addr.push_back(mem_addr);
                q_data.push_back(mem_we ? mem_wdata : mem[mem_addr[5:2]]);
                if (mem_we) mem[mem_addr[5:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[5:2]];
            end else begin
                wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'(cycles), 32'd100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_op(input logic [1:0] op, input logic [31:0] addr,
                         input logic [31:0] wd, input bit noise);
        logic [31:0] old_word, res, p_addr, p_wd;
        bit p_req, p_rdy, p_we, is_swap, is_store;
        old_word = mem[addr[5:2]];
        is_swap  = (op == 2'b10);
        is_store = (op == 2'b01);
        q_we.delete(); q_addr.delete(); q_data.delete();
        @(negedge clk); #1;
        core_req = 1'b1; core_op = op; core_addr = addr; core_wdata = wd;
        p_req = 0; p_rdy = 0; p_we = 0; p_addr = '0; p_wd = '0;
        forever begin
            @(negedge clk); #1;
            if (noise) begin
                core_req = 1'b1; core_op = 2'b01; core_addr = 32'hFFFF_FFC3; core_wdata = 32'hDEAD_BEEF;
            end else begin
                core_req = 1'b0;
            end
            if (core_done) break;
            chk(core_ready == 1'b0, "R10", "ready while busy", 32'(core_ready), 32'd0);
            chk(mem_lock == (is_swap && mem_req), "R9", "lock level", 32'(mem_lock), 32'(is_swap && mem_req));
            if (mem_req && mem_we)
                chk(mem_addr[1:0] == 2'b00, "R5", "write addr low bits", mem_addr, {mem_addr[31:2], 2'b00});
            if (p_req && !p_rdy)
                chk(mem_req && mem_we == p_we && mem_addr == p_addr && mem_wdata == p_wd,
                    "R11", "held request", mem_addr, p_addr);
            p_req = mem_req; p_rdy = mem_ready; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
        end
        core_req = 1'b0;
        res = core_rdata;
        chk(mem_lock == 1'b0, "R9", "lock after done", 32'(mem_lock), 32'd0);
        if (is_store) begin
            chk(q_we.size() == 1, "R4", "store access count", 32'(q_we.size()), 32'd1);
            if (q_we.size() >= 1) begin
                chk(q_we[0] == 1'b1, "R5", "store is write", 32'(q_we[0]), 32'd1);
                chk(q_addr[0] == {addr[31:2], 2'b00}, "R5", "store addr", q_addr[0], {addr[31:2], 2'b00});
                chk(q_data[0] == wd, "R6", "store data", q_data[0], wd);
            end
        end else if (is_swap) begin
            chk(q_we.size() == 2, "R7", "swap access count", 32'(q_we.size()), 32'd2);
            if (q_we.size() == 2) begin
                chk(q_we[0] == 1'b0 && q_we[1] == 1'b1, "R7", "swap order", {q_we[0], q_we[1]}, 32'b01);
                chk(q_addr[0] == addr, "R7", "swap read addr", q_addr[0], addr);
                chk(q_addr[1] == {addr[31:2], 2'b00}, "R7", "swap write addr", q_addr[1], {addr[31:2], 2'b00});
                chk(q_data[1] == wd, "R8", "swap write data", q_data[1], wd);
            end
            chk(res == ref_rot(old_word, addr[1:0]), "R8", "swap result", res, ref_rot(old_word, addr[1:0]));
        end else begin
            chk(q_we.size() == 1, "R4", "load access count", 32'(q_we.size()), 32'd1);
            if (q_we.size() >= 1) begin
                chk(q_we[0] == 1'b0 && q_addr[0] == addr, "R2", "load addr", q_addr[0], addr);
            end
            chk(res == ref_rot(old_word, addr[1:0]), "R3", "load result", res, ref_rot(old_word, addr[1:0]));
        end
        @(negedge clk); #1;
        chk(core_done == 1'b0 && core_ready == 1'b1, "R12", "done pulse ends",
            {core_done, core_ready}, 32'b01);
        chk(mem_req == 1'b0, "R10", "no access from held request", 32'(mem_req), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hA1B2C3D4 ^ (i * 32'h01030507);
        repeat (3) @(negedge clk);
        #1;
        chk(core_ready == 1'b1 && core_done == 1'b0, "R1", "reset ready/done", {core_ready, core_done}, 32'b10);
        chk(mem_req == 1'b0 && mem_lock == 1'b0, "R1", "reset bus idle", {mem_req, mem_lock}, 32'b00);
        rst = 1'b0;
        // R3 loads at every offset, varied wait
        for (int o = 0; o < 4; o++) begin
            lat = o;
            do_op(2'b00, 32'h0000_0010 + 32'(o), '0, 1'b0);
        end
        lat = 0;
        do_op(2'b11, 32'h0000_0027, '0, 1'b0);          // R2 code 11 loads
        // R5 R6 stores at every offset
        for (int o = 0; o < 4; o++) begin
            lat = (o == 2) ? 2 : 0;
            do_op(2'b01, 32'h0000_0020 + 32'(4*o + o), 32'h8000_0001 + 32'(o << 8), o[0]);
        end
        for (int o = 0; o < 4; o++) do_op(2'b00, 32'h0000_0020 + 32'(4*o), '0, 1'b0);
        // R7 R8 R9 swaps, with held noise request (R10)
        for (int o = 0; o < 4; o++) begin
            lat = (o == 3) ? 3 : o[0];
            do_op(2'b10, 32'h0000_0030 + 32'(o), 32'hCAFE_0000 + 32'(o), 1'b1);
        end
        for (int o = 0; o < 4; o++) do_op(2'b00, 32'h0000_0031 + 32'(o), '0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule